// File: doc/BRIEF.md
# Fault-Injectable Address Decoder RAM

This block is a small synchronous RAM whose address decoding can be corrupted at run time. It lets a memory test algorithm, such as a march sequence or a built-in self-test engine, run against a memory whose decoder misbehaves in a known way. Each run can then show whether the algorithm catches the fault. The data side is a single port with a clock, an address, a write enable, write data and registered read data. Every clock cycle is one access: a write when `we` is high, a read otherwise.

A configuration side picks the fault case and supplies two addresses and a bit index. The decoder turns the access address into a cell-select vector, and that vector may have zero, one or two bits set. A write stores the data into every selected cell. A read returns the bitwise AND of all selected cells. When no cell is selected, that AND is all ones, so a read never returns stored data.

The sequential stuck-open case keeps one flop of state: the word line of a target address. That line can only be released through the broken transistor, so the line's state depends on the previous access.

Top module: `fault_addr_ram`

## Requirements
- R1: While `rst` is high, `rdata` is cleared to zero at each rising clock edge, and no write reaches the array.
- R2: With `fault_mode` 0 (and also the unused codes 6 and 7), the block is a plain RAM. A read of address n presents the contents of cell n on `rdata` after the next rising edge (one cycle of latency). A write updates only cell n.
- R3: `fault_mode` 1 (dead address): address `fault_addr_a` selects no cell. A write to it changes no cell, and a read of it returns all ones.
- R4: `fault_mode` 2 (lost cell): no address reaches cell `fault_addr_a`. Reads of that address return all ones, writes to it are lost, and every other address behaves normally.
- R5: `fault_mode` 3 (dual select): address `fault_addr_a` selects its own cell and cell `fault_addr_b`, and one write updates both. Address `fault_addr_b` still reaches only its own cell.
- R6: `fault_mode` 4 (shared cell): address `fault_addr_b` reaches cell `fault_addr_a` instead of its own cell, so cell `fault_addr_a` is reachable from two addresses and cell `fault_addr_b` keeps its contents.
- R7: In every mode, the mapping from address to cells is the same for reads and for writes.
- R8: When a read selects two cells, it returns their common value if they are equal and the bitwise AND of the two if they differ.
- R9: `fault_mode` 5 (stuck open) follows this sequence, with T = `fault_addr_a` and neighbour N = T with bit `fault_bit` inverted. Write ones to T. Write zeros to an address that differs from T in bit `fault_bit` and in at least one more bit. A read of T then returns the ones. Write zeros to N. A read of T now returns zeros.
- R10: In stuck-open mode, the word line of T is set by an access to T and cleared by an access to any address other than T or N. An access to N leaves the line as the previous access left it, so after an access to T, an access to N selects both N and T. The line is clear after reset and in every other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| fault_mode | input | 3 | Fault case: 0 none, 1 dead address, 2 lost cell, 3 dual select, 4 shared cell, 5 stuck open |
| fault_addr_a | input | ADDR_W | First fault address or cell (target in stuck-open mode) |
| fault_addr_b | input | ADDR_W | Second fault address or cell |
| fault_bit | input | BIT_W | Address bit whose decoder transistor is open in stuck-open mode |
| we | input | 1 | Write enable; low means read |
| addr | input | ADDR_W | Access address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |

## Verification
The bench builds the block with ADDR_W = 4 and DATA_W = 8, giving 16 cells and two bit-index lines. That is small enough to preload every cell with a distinct value. After each faulty access, the bench switches back to mode 0 and reads the touched cells, which shows at the ports which cells the fault reached and which it spared. With four address bits, the stuck-open target 14, its neighbour 6 and the far address 4 can all be placed so that bit 3 separates T from N while address 4 also differs from T in bit 1.

// File: rtl/fault_addr_pkg.sv
package fault_addr_pkg;

  typedef enum logic [2:0] {
    FM_NONE        = 3'd0,
    FM_DEAD_ADDR   = 3'd1,
    FM_LOST_CELL   = 3'd2,
    FM_DUAL_SEL    = 3'd3,
    FM_SHARED_CELL = 3'd4,
    FM_STUCK_OPEN  = 3'd5
  } fault_mode_e;

endpackage

// File: rtl/fa_decoder.sv
module fa_decoder
  import fault_addr_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DEPTH  = 1 << ADDR_W,
  parameter int BIT_W  = (ADDR_W > 1) ? $clog2(ADDR_W) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        mode,
  input  logic [ADDR_W-1:0] tgt_a,
  input  logic [ADDR_W-1:0] tgt_b,
  input  logic [BIT_W-1:0]  bit_sel,
  input  logic [ADDR_W-1:0] addr,
  output logic [DEPTH-1:0]  sel
);

  fault_mode_e       mode_e;
  logic [DEPTH-1:0]  plain;
  logic [ADDR_W-1:0] neigh;
  logic              line_q;
  logic              line_now;

  assign mode_e = fault_mode_e'(mode);
  assign neigh  = tgt_a ^ (ADDR_W'(1) << bit_sel);

  // fault-free one-hot word-line decode
  for (genvar i = 0; i < DEPTH; i++) begin : g_plain
    assign plain[i] = (addr == ADDR_W'(i));
  end

  // target word line: driven on by its own address, pulled off by any
  // address that does not need the broken device, floating for the neighbour
  always_comb begin
    if (addr == tgt_a)      line_now = 1'b1;
    else if (addr == neigh) line_now = line_q;
    else                    line_now = 1'b0;
  end

  always_comb begin
    sel = plain;
    case (mode_e)
      FM_DEAD_ADDR: begin
        if (addr == tgt_a) sel = '0;
      end
      FM_LOST_CELL: begin
        sel[tgt_a] = 1'b0;
      end
      FM_DUAL_SEL: begin
        if (addr == tgt_a) sel[tgt_b] = 1'b1;
      end
      FM_SHARED_CELL: begin
        if (addr == tgt_b) begin
          sel        = '0;
          sel[tgt_a] = 1'b1;
        end
      end
      FM_STUCK_OPEN: begin
        sel[tgt_a] = line_now;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                         line_q <= 1'b0;
    else if (mode_e == FM_STUCK_OPEN) line_q <= line_now;
    else                             line_q <= 1'b0;
  end

endmodule

// File: rtl/fa_cell_array.sv
module fa_cell_array #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DEPTH-1:0]  sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] merged;

  // every selected cell takes the write
  always_ff @(posedge clk) begin
    if (we && !rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (sel[i]) mem[i] <= wdata;
      end
    end
  end

  // wired-AND read of all selected cells; empty selection reads all ones
  always_comb begin
    merged = '1;
    for (int i = 0; i < DEPTH; i++) begin
      if (sel[i]) merged = merged & mem[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= merged;
  end

endmodule

// File: rtl/fault_addr_ram.sv
module fault_addr_ram #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int BIT_W = (ADDR_W > 1) ? $clog2(ADDR_W) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        fault_mode,
  input  logic [ADDR_W-1:0] fault_addr_a,
  input  logic [ADDR_W-1:0] fault_addr_b,
  input  logic [BIT_W-1:0]  fault_bit,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DEPTH-1:0] sel_vec;

  fa_decoder #(
    .ADDR_W (ADDR_W),
    .DEPTH  (DEPTH),
    .BIT_W  (BIT_W)
  ) u_dec (
    .clk     (clk),
    .rst     (rst),
    .mode    (fault_mode),
    .tgt_a   (fault_addr_a),
    .tgt_b   (fault_addr_b),
    .bit_sel (fault_bit),
    .addr    (addr),
    .sel     (sel_vec)
  );

  fa_cell_array #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) u_arr (
    .clk   (clk),
    .rst   (rst),
    .we    (we),
    .sel   (sel_vec),
    .wdata (wdata),
    .rdata (rdata)
  );

endmodule

// File: rtl/fault_addr_ram_chk.sv
module fault_addr_ram_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int BIT_W = (ADDR_W > 1) ? $clog2(ADDR_W) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        fault_mode,
  input logic [ADDR_W-1:0] fault_addr_a,
  input logic [ADDR_W-1:0] fault_addr_b,
  input logic [BIT_W-1:0]  fault_bit,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic [DEPTH-1:0]  sel
);

  logic [1:0]        age;
  logic              aged;
  logic [ADDR_W-1:0] neigh;

  always_ff @(posedge clk) begin
    if (rst)            age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end
  assign aged  = (age != 2'd0);
  assign neigh = fault_addr_a ^ (ADDR_W'(1) << fault_bit);

  AST_RESET_CLEARS_RDATA: assert property (@(posedge clk)
    rst |=> (rdata == '0)); // R1

  AST_PLAIN_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
    (fault_mode == 3'd0) |-> $onehot(sel)); // R2

  AST_PLAIN_READBACK: assert property (@(posedge clk) disable iff (rst)
    (aged && !we && $past(we) && fault_mode == 3'd0 && $past(fault_mode) == 3'd0
     && $past(addr) == addr) |=> (rdata == $past(wdata, 2))); // R2

  AST_DEAD_READS_ONES: assert property (@(posedge clk) disable iff (rst)
    (fault_mode == 3'd1 && !we && addr == fault_addr_a) |=> (rdata == '1)); // R3

  AST_LOST_NEVER_SELECTED: assert property (@(posedge clk) disable iff (rst)
    (fault_mode == 3'd2) |-> !sel[fault_addr_a]); // R4

  AST_DUAL_TWO_CELLS: assert property (@(posedge clk) disable iff (rst)
    (fault_mode == 3'd3 && addr == fault_addr_a && fault_addr_a != fault_addr_b)
    |-> ($countones(sel) == 2)); // R5

  AST_SHARED_ALIAS: assert property (@(posedge clk) disable iff (rst)
    (fault_mode == 3'd4 && addr == fault_addr_b && fault_addr_a != fault_addr_b)
    |-> (sel[fault_addr_a] && $onehot(sel))); // R6

  AST_STUCK_NEIGH_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (aged && fault_mode == 3'd5 && $past(fault_mode) == 3'd5
     && $stable(fault_addr_a) && $stable(fault_bit)
     && $past(addr) == fault_addr_a && addr == neigh)
    |-> ($countones(sel) == 2)); // R10

endmodule

bind fault_addr_ram fault_addr_ram_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .fault_mode   (fault_mode),
  .fault_addr_a (fault_addr_a),
  .fault_addr_b (fault_addr_b),
  .fault_bit    (fault_bit),
  .we           (we),
  .addr         (addr),
  .wdata        (wdata),
  .rdata        (rdata),
  .sel          (sel_vec)
);

// File: tb/fault_addr_ram_bench.sv
module fault_addr_ram_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 4;
  localparam int DATA_W     = 8;
  localparam int WATCHDOG   = 5000;

  localparam logic [2:0] M_NONE   = 3'd0;
  localparam logic [2:0] M_DEAD   = 3'd1;
  localparam logic [2:0] M_LOST   = 3'd2;
  localparam logic [2:0] M_DUAL   = 3'd3;
  localparam logic [2:0] M_SHARED = 3'd4;
  localparam logic [2:0] M_STUCK  = 3'd5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [2:0]        fault_mode = M_NONE;
  logic [ADDR_W-1:0] fault_addr_a = '0;
  logic [ADDR_W-1:0] fault_addr_b = '0;
  logic [1:0]        fault_bit = '0;
  logic              we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;

  int checks = 0;
  int errors = 0;

  bit                chk_q [$];
  logic [DATA_W-1:0] exp_q [$];
  string             req_q [$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  fault_addr_ram #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_fault_addr_ram (
    .clk          (clk),
    .rst          (rst),
    .fault_mode   (fault_mode),
    .fault_addr_a (fault_addr_a),
    .fault_addr_b (fault_addr_b),
    .fault_bit    (fault_bit),
    .we           (we),
    .addr         (addr),
    .wdata        (wdata),
    .rdata        (rdata)
  );

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // driver: one access per cycle, inputs change on the falling edge
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    we = 1'b1; addr = a; wdata = d;
    chk_q.push_back(1'b0); exp_q.push_back('0); req_q.push_back("");
    @(negedge clk);
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e,
                    input string req);
    we = 1'b0; addr = a; wdata = '0;
    chk_q.push_back(1'b1); exp_q.push_back(e); req_q.push_back(req);
    @(negedge clk);
  endtask

  task automatic cfg(input logic [2:0] m, input logic [ADDR_W-1:0] a,
                     input logic [ADDR_W-1:0] b, input logic [1:0] bt);
    fault_mode = m; fault_addr_a = a; fault_addr_b = b; fault_bit = bt;
  endtask

  // monitor: compares the result captured at each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (chk_q.size() > 0) begin
        bit                c;
        logic [DATA_W-1:0] e;
        string             r;
        c = chk_q.pop_front();
        e = exp_q.pop_front();
        r = req_q.pop_front();
        if (c) begin
          checks++;
          if (rdata !== e) begin
            errors++;
            $display("FAIL %s: rdata=%h expected=%h", r, rdata, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    // R1: reset clears the read register, write during reset is dropped
    we = 1'b1; addr = 4'd0; wdata = 8'hEE;
    repeat (3) @(negedge clk);
    checks++;
    if (rdata !== 8'h00) begin
      errors++;
      $display("FAIL R1: rdata=%h expected=%h", rdata, 8'h00);
    end
    we = 1'b0;
    rst = 1'b0;

    // preload every cell with 0x10 + index in fault-free mode
    cfg(M_NONE, 4'd0, 4'd0, 2'd0);
    for (int i = 0; i < 16; i++) wr(4'(i), 8'(8'h10 + i));

    // R2: plain RAM behaviour, including unused mode codes
    rd(4'd3, 8'h13, "R2");
    wr(4'd3, 8'hA5);
    rd(4'd3, 8'hA5, "R2");
    rd(4'd0, 8'h10, "R2");
    cfg(3'd6, 4'd4, 4'd5, 2'd0);
    wr(4'd4, 8'hC4);
    rd(4'd4, 8'hC4, "R2");
    cfg(3'd7, 4'd4, 4'd5, 2'd0);
    rd(4'd5, 8'h15, "R2");

    // R3: dead address 5
    cfg(M_DEAD, 4'd5, 4'd0, 2'd0);
    wr(4'd5, 8'h77);
    rd(4'd5, 8'hFF, "R3");
    rd(4'd6, 8'h16, "R3");
    cfg(M_NONE, 4'd0, 4'd0, 2'd0);
    rd(4'd5, 8'h15, "R3");

    // R4: lost cell 7
    cfg(M_LOST, 4'd7, 4'd0, 2'd0);
    rd(4'd7, 8'hFF, "R4");
    wr(4'd7, 8'h99);
    wr(4'd8, 8'h88);
    rd(4'd8, 8'h88, "R4");
    cfg(M_NONE, 4'd0, 4'd0, 2'd0);
    rd(4'd7, 8'h17, "R4");

    // R5, R7, R8: address 2 also selects cell 9
    cfg(M_DUAL, 4'd2, 4'd9, 2'd0);
    wr(4'd2, 8'h3C);
    cfg(M_NONE, 4'd0, 4'd0, 2'd0);
    rd(4'd2, 8'h3C, "R5");
    rd(4'd9, 8'h3C, "R5");
    cfg(M_DUAL, 4'd2, 4'd9, 2'd0);
    wr(4'd9, 8'h0F);
    rd(4'd9, 8'h0F, "R5");
    rd(4'd2, 8'h0C, "R8");
    wr(4'd2, 8'h5A);
    rd(4'd2, 8'h5A, "R8");

    // R6, R7: address 11 reaches cell 10
    cfg(M_SHARED, 4'd10, 4'd11, 2'd0);
    wr(4'd11, 8'hE1);
    rd(4'd11, 8'hE1, "R7");
    rd(4'd10, 8'hE1, "R6");
    cfg(M_NONE, 4'd0, 4'd0, 2'd0);
    rd(4'd11, 8'h1B, "R6");
    rd(4'd10, 8'hE1, "R6");

    // R9: T=14, bit 3, N=6, far address X=4
    cfg(M_STUCK, 4'd14, 4'd0, 2'd3);
    wr(4'd14, 8'hFF);
    wr(4'd4, 8'h00);
    rd(4'd14, 8'hFF, "R9");
    wr(4'd6, 8'h00);
    rd(4'd14, 8'h00, "R9");

    // R10: far access clears the line, so N alone is written
    rd(4'd4, 8'h00, "R10");
    wr(4'd6, 8'hAA);
    cfg(M_NONE, 4'd0, 4'd0, 2'd0);
    rd(4'd14, 8'h00, "R10");
    rd(4'd6, 8'hAA, "R10");
    cfg(M_STUCK, 4'd14, 4'd0, 2'd3);
    wr(4'd14, 8'hF0);
    rd(4'd6, 8'hA0, "R10");
    cfg(M_NONE, 4'd0, 4'd0, 2'd0);
    rd(4'd6, 8'hAA, "R10");

    @(negedge clk);
    @(negedge clk);
    summary();
    $finish;
  end

endmodule